// File: doc/BRIEF.md
# Cache-Line Write Command Selector

This block sits in the DMA write path of a PCI bus master. At the start of each write burst it decides whether the burst goes out as a plain Memory Write or as a Memory Write and Invalidate, and it sets the length of the burst in dwords. The invalidating write promises the target that whole cache lines are written, so the block grants it only when the configuration allows it, the cache line size is usable, the DMA FIFO can supply at least one full line, and the write address starts a line.

When a preceding multiple-line read has left several lines of data in the FIFO, the block lengthens an invalidating burst so that all of those lines move in one bus ownership. It never lengthens the burst past the data the FIFO holds. The decision is captured on a start-of-burst strobe and held until the next strobe, so the bus interface sees one stable command and length for the whole ownership.

Top module: `cls_write_cmd_sel`

## Requirements
- R1: While reset is high, and after it until the first start strobe, the command output is 4'b0111 and the burst length is 0.
- R2: The invalidating write is chosen only if all three enable inputs (line-size enable, write-invalidate enable, PCI command bit 4) are 1.
- R3: The invalidating write is chosen only if the line size input is 2, 4, 8 or 16 dwords.
- R4: The invalidating write is chosen only if the line size is less than or equal to the programmed maximum burst length.
- R5: The invalidating write is chosen only if the FIFO byte count is at least 4 times the line size.
- R6: The invalidating write is chosen only if byte address bits [log2(line size)+1:2] are all zero; bits [1:0] are not looked at.
- R7: When every condition of R2 to R6 holds, the command is 4'b1111 and, with fewer than two whole lines prefetched, the burst length equals the line size.
- R8: For an invalidating write, the burst length is the line size times the smaller of (prefetched dwords / line size) and (FIFO bytes / 4 / line size), both rounded down, and never less than one line.
- R9: When any condition of R2 to R6 fails, the command is 4'b0111 and the burst length equals the programmed maximum burst length.
- R10: Command and length are updated only at a clock edge where the start strobe is 1 and hold their value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-burst strobe; captures a new decision |
| cls_en_i | input | 1 | Cache line size enable |
| wi_en_i | input | 1 | Write-and-invalidate enable from chip control |
| cmd_mwi_en_i | input | 1 | PCI command register bit 4 |
| line_size_i | input | 8 | Cache line size in dwords |
| max_burst_i | input | LEN_W | Programmed maximum DMA burst in dwords |
| fifo_bytes_i | input | FIFO_W | DMA FIFO fill level in bytes |
| addr_i | input | ADDR_W | Byte address of the next write |
| prefetch_dw_i | input | LEN_W | Dwords buffered by a preceding multiple-line read |
| cmd_o | output | 4 | PCI command code: 4'b0111 or 4'b1111 |
| burst_len_o | output | LEN_W | Burst length in dwords |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 8-bit burst and prefetch counts, and a 10-bit FIFO byte count. The 10-bit FIFO count reaches up to 255 dwords, so with 2-dword lines a multi-line burst can be limited by either the prefetch count or the FIFO, and with 16-dword lines the FIFO can sit just below and just above one full line. The 8-bit line size input lets illegal values such as 0, 3 and 32 be applied beside the four legal ones, and full 32-bit addresses exercise every alignment mask width.

// File: rtl/cls_pkg.sv
package cls_pkg;

    typedef enum logic [3:0] {
        CMD_MEM_WRITE     = 4'b0111,
        CMD_MEM_WRITE_INV = 4'b1111
    } pci_cmd_e;

    typedef struct packed {
        logic en_ok;
        logic size_ok;
        logic fits_burst;
        logic fifo_ok;
        logic aligned;
    } mwi_checks_t;

    // log2 of a legal line size; 0 marks an illegal size
    function automatic logic [2:0] line_shift(input logic [7:0] ls);
        case (ls)
            8'd2:    return 3'd1;
            8'd4:    return 3'd2;
            8'd8:    return 3'd3;
            8'd16:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cls_eligibility.sv
module cls_eligibility
    import cls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int FIFO_W = 10
) (
    input  logic              cls_en_i,
    input  logic              wi_en_i,
    input  logic              cmd_mwi_en_i,
    input  logic [7:0]        line_size_i,
    input  logic [LEN_W-1:0]  max_burst_i,
    input  logic [FIFO_W-1:0] fifo_bytes_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [2:0]        shift_o,
    output mwi_checks_t       checks_o,
    output logic              eligible_o
);
    localparam int CW = ((LEN_W > FIFO_W) ? LEN_W : FIFO_W) + 10;

    logic [ADDR_W-1:0] line_mask;
    logic [ADDR_W-1:0] dword_addr;

    always_comb begin
        shift_o             = line_shift(line_size_i);
        line_mask           = (ADDR_W'(1) << shift_o) - ADDR_W'(1);
        dword_addr          = addr_i >> 2;
        checks_o.en_ok      = cls_en_i & wi_en_i & cmd_mwi_en_i;
        checks_o.size_ok    = (shift_o != 3'd0);
        checks_o.fits_burst = CW'(line_size_i) <= CW'(max_burst_i);
        checks_o.fifo_ok    = CW'(fifo_bytes_i) >= (CW'(line_size_i) << 2);
        checks_o.aligned    = (dword_addr & line_mask) == '0;
        eligible_o          = &checks_o;
    end

endmodule

// File: rtl/cls_burst_sizer.sv
module cls_burst_sizer #(
    parameter int LEN_W  = 8,
    parameter int FIFO_W = 10
) (
    input  logic [2:0]        shift_i,
    input  logic [LEN_W-1:0]  prefetch_dw_i,
    input  logic [FIFO_W-1:0] fifo_bytes_i,
    output logic [LEN_W-1:0]  len_o
);
    localparam int CW = ((LEN_W > FIFO_W) ? LEN_W : FIFO_W) + 5;

    logic [CW-1:0] pref_lines;
    logic [CW-1:0] fifo_lines;
    logic [CW-1:0] n_lines;
    logic [CW-1:0] full_len;

    always_comb begin
        pref_lines = CW'(prefetch_dw_i) >> shift_i;
        fifo_lines = (CW'(fifo_bytes_i) >> 2) >> shift_i;
        n_lines    = (pref_lines < fifo_lines) ? pref_lines : fifo_lines;
        if (n_lines == '0) n_lines = CW'(1);
        full_len   = n_lines << shift_i;
        len_o      = LEN_W'(full_len);
    end

endmodule

// File: rtl/cls_write_cmd_sel.sv
module cls_write_cmd_sel
    import cls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int FIFO_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cls_en_i,
    input  logic              wi_en_i,
    input  logic              cmd_mwi_en_i,
    input  logic [7:0]        line_size_i,
    input  logic [LEN_W-1:0]  max_burst_i,
    input  logic [FIFO_W-1:0] fifo_bytes_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  prefetch_dw_i,
    output logic [3:0]        cmd_o,
    output logic [LEN_W-1:0]  burst_len_o
);
    logic [2:0]       shift;
    mwi_checks_t      checks;
    logic             eligible;
    logic [LEN_W-1:0] sized_len;
    pci_cmd_e         cmd_q;

    cls_eligibility #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_W(FIFO_W)) u_elig (
        .cls_en_i     (cls_en_i),
        .wi_en_i      (wi_en_i),
        .cmd_mwi_en_i (cmd_mwi_en_i),
        .line_size_i  (line_size_i),
        .max_burst_i  (max_burst_i),
        .fifo_bytes_i (fifo_bytes_i),
        .addr_i       (addr_i),
        .shift_o      (shift),
        .checks_o     (checks),
        .eligible_o   (eligible)
    );

    cls_burst_sizer #(.LEN_W(LEN_W), .FIFO_W(FIFO_W)) u_sizer (
        .shift_i       (shift),
        .prefetch_dw_i (prefetch_dw_i),
        .fifo_bytes_i  (fifo_bytes_i),
        .len_o         (sized_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= CMD_MEM_WRITE;
            burst_len_o <= '0;
        end else if (start_i) begin
            if (eligible) begin
                cmd_q       <= CMD_MEM_WRITE_INV;
                burst_len_o <= sized_len;
            end else begin
                cmd_q       <= CMD_MEM_WRITE;
                burst_len_o <= max_burst_i;
            end
        end
    end

    assign cmd_o = cmd_q;

    // R10: outputs only move on a start strobe
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(cmd_o) && $stable(burst_len_o)));

    // R2: missing enable forces a plain write
    p_enables_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !(cls_en_i && wi_en_i && cmd_mwi_en_i)) |=> cmd_o == 4'b0111);

    // R3: illegal line size forces a plain write
    p_size_r3: assert property (@(posedge clk) disable iff (rst)
        (start_i && !(line_size_i inside {8'd2, 8'd4, 8'd8, 8'd16})) |=> cmd_o == 4'b0111);

    // R5: an eligible burst always has a full line in the FIFO
    p_fifo_r5: assert property (@(posedge clk) disable iff (rst)
        eligible |-> (32'(fifo_bytes_i) >= 32'(line_size_i) * 32'd4));

    // R8: sized burst is a whole, nonzero number of lines
    p_whole_lines_r8: assert property (@(posedge clk) disable iff (rst)
        eligible |-> ((32'(sized_len) >= 32'(line_size_i)) &&
                      ((32'(sized_len) & (32'(line_size_i) - 32'd1)) == 32'd0)));

endmodule

// File: tb/test_cls_write_cmd_sel.sv
module test_cls_write_cmd_sel;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;
    localparam int FIFO_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              cls_en_i = 1'b0;
    logic              wi_en_i = 1'b0;
    logic              cmd_mwi_en_i = 1'b0;
    logic [7:0]        line_size_i = '0;
    logic [LEN_W-1:0]  max_burst_i = '0;
    logic [FIFO_W-1:0] fifo_bytes_i = '0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [LEN_W-1:0]  prefetch_dw_i = '0;
    logic [3:0]        cmd_o;
    logic [LEN_W-1:0]  burst_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_cmd = 7;
    int exp_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cls_write_cmd_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_W(FIFO_W)) i_cls_write_cmd_sel (
        .clk(clk), .rst(rst), .start_i(start_i), .cls_en_i(cls_en_i), .wi_en_i(wi_en_i),
        .cmd_mwi_en_i(cmd_mwi_en_i), .line_size_i(line_size_i), .max_burst_i(max_burst_i),
        .fifo_bytes_i(fifo_bytes_i), .addr_i(addr_i), .prefetch_dw_i(prefetch_dw_i),
        .cmd_o(cmd_o), .burst_len_o(burst_len_o)
    );

    // behavioural reference: integer arithmetic straight from the requirements
    function automatic bit model_ok();
        int ls = int'(line_size_i);
        bit legal = (ls == 2) || (ls == 4) || (ls == 8) || (ls == 16);
        if (!(cls_en_i && wi_en_i && cmd_mwi_en_i)) return 0;
        if (!legal) return 0;
        if (ls > int'(max_burst_i)) return 0;
        if (int'(fifo_bytes_i) < 4 * ls) return 0;
        if (((int'(addr_i) >>> 2) & 32'h3fffffff) % ls != 0) return 0;
        return 1;
    endfunction

    function automatic int model_len();
        int ls = int'(line_size_i);
        int a  = int'(prefetch_dw_i) / ls;
        int b  = (int'(fifo_bytes_i) / 4) / ls;
        int n  = (a < b) ? a : b;
        if (n < 1) n = 1;
        return (ls * n) % 256;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (int'(cmd_o) != exp_cmd || int'(burst_len_o) != exp_len) begin
            errors++;
            $display("FAIL %s: cmd=%h len=%0d expected cmd=%h len=%0d",
                     tag, cmd_o, burst_len_o, exp_cmd[3:0], exp_len);
        end
    endtask

    // called at a negedge with inputs already set
    task automatic step(input bit strobe, input string tag);
        start_i = strobe;
        if (strobe) begin
            if (model_ok()) begin
                exp_cmd = 15;
                exp_len = model_len();
            end else begin
                exp_cmd = 7;
                exp_len = int'(max_burst_i);
            end
        end
        @(negedge clk);
        compare(tag);
        start_i = 1'b0;
    endtask

    task automatic set_base();
        cls_en_i = 1; wi_en_i = 1; cmd_mwi_en_i = 1;
        line_size_i = 8'd4; max_burst_i = 8'd16; fifo_bytes_i = 10'd64;
        addr_i = 32'h100; prefetch_dw_i = 8'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        compare("R1 after reset");
        set_base();
        step(0, "R1 no strobe yet");

        set_base();                       step(1, "R7 basic MWI len 4");
        set_base(); prefetch_dw_i = 16;   step(1, "R8 prefetch 16 -> 16");
        set_base(); prefetch_dw_i = 16; fifo_bytes_i = 40; step(1, "R8 fifo limits to 8");
        set_base(); prefetch_dw_i = 6;    step(1, "R7 partial prefetch -> 4");
        set_base(); line_size_i = 2; prefetch_dw_i = 255; fifo_bytes_i = 1023;
        addr_i = 32'h8; step(1, "R8 large multi-line");
        set_base(); prefetch_dw_i = 16;   step(1, "R8 setup before hold");
        line_size_i = 3; fifo_bytes_i = 0; cls_en_i = 0;
        step(0, "R10 hold with changed inputs");
        step(0, "R10 hold second cycle");

        set_base(); cls_en_i = 0;         step(1, "R2 line-size enable off");
        set_base(); wi_en_i = 0;          step(1, "R2 write-inv enable off");
        set_base(); cmd_mwi_en_i = 0;     step(1, "R2 command bit 4 off");
        set_base(); line_size_i = 3;      step(1, "R3 size 3 illegal");
        set_base(); line_size_i = 0;      step(1, "R3 size 0 illegal");
        set_base(); line_size_i = 32; fifo_bytes_i = 1000; max_burst_i = 64;
        step(1, "R3 size 32 illegal");
        set_base(); line_size_i = 16; addr_i = 32'h40; step(1, "R4 line equal burst");
        set_base(); line_size_i = 16; max_burst_i = 8; step(1, "R4 line above burst");
        set_base(); fifo_bytes_i = 15;    step(1, "R5 fifo one byte short");
        set_base(); fifo_bytes_i = 16;    step(1, "R5 fifo exact line");
        set_base(); addr_i = 32'h104;     step(1, "R6 misaligned");
        set_base(); addr_i = 32'h102;     step(1, "R6 byte bits ignored");
        set_base(); line_size_i = 16; addr_i = 32'h120; step(1, "R6 misaligned 16");
        set_base(); max_burst_i = 3; line_size_i = 4; step(1, "R9 plain uses max burst");

        for (int i = 0; i < 400; i++) begin
            int pick = $urandom_range(0, 7);
            cls_en_i     = ($urandom_range(0, 7) != 0);
            wi_en_i      = ($urandom_range(0, 7) != 0);
            cmd_mwi_en_i = ($urandom_range(0, 7) != 0);
            case (pick)
                0: line_size_i = 8'd2;  1: line_size_i = 8'd4;
                2: line_size_i = 8'd8;  3: line_size_i = 8'd16;
                4: line_size_i = 8'd0;  5: line_size_i = 8'd6;
                6: line_size_i = 8'd32; default: line_size_i = 8'd4;
            endcase
            max_burst_i   = LEN_W'($urandom_range(0, 64));
            fifo_bytes_i  = FIFO_W'($urandom_range(0, 1023));
            addr_i        = $urandom & (($urandom_range(0, 1) != 0) ? 32'hffffffc0 : 32'hffffffff);
            prefetch_dw_i = LEN_W'($urandom_range(0, 255));
            step($urandom_range(0, 2) != 0, "R7/R8/R9/R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule